// File: doc/BRIEF.md
# Chip-Selected Bidirectional Bit Memory

This block is a four-location, one-bit-wide read/write store that sits on a single shared bidirectional data line. An address of two bits picks one storage element. A chip-select input gates all activity, and a direction input chooses between reading and writing.

During a selected write, the level on the data line is copied into the addressed element on the falling clock edge. During a selected read, the block drives the addressed element's contents onto the line. The read path is combinational, so the line follows the address without waiting for a clock edge. At all other times the line is released to high impedance.

A separate output reports when the block is driving the line. The surrounding logic and the testbench use it to see bus ownership directly. Stored contents are undefined after power-up, and there is no reset.

Top module: `selbit_mem`

## Requirements
- R1: The element index is computed as 2*addrBits[1] + addrBits[0], so addrBits[1] is the high bit and addrBits[0] is the low bit.
- R2: rdWr = 1 selects a read and rdWr = 0 selects a write. The direction has an effect only while chipSel = 1.
- R3: While chipSel = 0, no element changes on any clock edge, driveEn = 0, and the block does not drive dataLine, whatever rdWr, the address and dataLine are.
- R4: While chipSel = 1 and rdWr = 1, driveEn = 1 and dataLine carries the addressed element. This happens combinationally, within the same clock phase as the input change.
- R5: While chipSel = 1 and rdWr = 0, the value on dataLine at a falling clock edge is stored into the addressed element.
- R6: Elements change only on falling clock edges. A rising edge that occurs while write inputs are applied leaves every element unchanged.
- R7: A write changes only the addressed element. The other three keep their values.
- R8: In write mode the block never drives dataLine, and driveEn = 0.
- R9: When chipSel falls after a read, driveEn returns to 0 and dataLine is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores happen on its falling edge |
| addrBits | input | 2 | Element address; bit 1 is the high bit |
| chipSel | input | 1 | Active-high select |
| rdWr | input | 1 | 1 = read, 0 = write |
| dataLine | inout | 1 | Shared tri-state data line |
| driveEn | output | 1 | High while the block drives dataLine |

## Verification
Two pairs of events can land in the same clock period.

The first pair is a write to one location and the read-back of all four locations. To provoke it, the bench writes each location in turn from every 4-bit content pattern, then reads every address immediately. It judges the result against a four-bit model updated only for the addressed index, which catches both lost writes and disturbed neighbours.

The second pair is a rising clock edge and applied write inputs. The bench raises the write inputs just after a falling edge and turns the cycle into a read before the next falling edge. The old contents must be read back. A deselected cycle that carries a conflicting line value must likewise leave the model intact.

// File: rtl/selbit_pkg.sv
package selbit_pkg;
  parameter int ADDR_W = 2;
  localparam int DEPTH = 1 << ADDR_W;

  typedef struct packed {
    logic [DEPTH-1:0] cellLoad;
    logic             busDrive;
  } selStrobes_t;
endpackage

// File: rtl/selbit_ctrl.sv
module selbit_ctrl
  import selbit_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addrBits,
  input  logic          chipSel,
  input  logic          rdWr,
  output selStrobes_t   strobes
);
  localparam int N = 1 << AW;

  logic wrSel;
  assign wrSel = chipSel && !rdWr;
  assign strobes.busDrive = chipSel && rdWr;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign strobes.cellLoad[i] = wrSel && (addrBits == AW'(i));
  end

  logic pastValid = 1'b0;
  always_ff @(negedge clk) pastValid <= 1'b1;

  // R7: at most one cell is enabled in any cycle
  a_r7_one_load: assert property (@(negedge clk) disable iff (!pastValid)
    $onehot0(strobes.cellLoad));
  // R3: a deselected chip neither loads a cell nor drives the line
  a_r3_idle_quiet: assert property (@(negedge clk) disable iff (!pastValid)
    !chipSel |-> (strobes.cellLoad == '0 && !strobes.busDrive));
  // R8: loading a cell and driving the line never coincide
  a_r8_no_drive_on_load: assert property (@(negedge clk) disable iff (!pastValid)
    (strobes.cellLoad != '0) |-> !strobes.busDrive);
endmodule

// File: rtl/selbit_datapath.sv
module selbit_datapath
  import selbit_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addrBits,
  input  selStrobes_t   strobes,
  input  logic          busIn,
  output logic          rdBit
);
  localparam int N = 1 << AW;

  logic [N-1:0] cellBits;

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(negedge clk) begin
      if (strobes.cellLoad[i]) cellBits[i] <= busIn;
    end
  end

  assign rdBit = cellBits[addrBits];

  logic pastValid = 1'b0;
  always_ff @(negedge clk) pastValid <= 1'b1;

  // R3/R6: with no load strobe, every cell holds across a falling edge
  a_r6_hold_unloaded: assert property (@(negedge clk) disable iff (!pastValid)
    (strobes.cellLoad == '0) |=> $stable(cellBits));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a loaded cell holds the value sampled from the line
    a_r5_capture: assert property (@(negedge clk) disable iff (!pastValid)
      strobes.cellLoad[i] |=> (cellBits[i] == $past(busIn)));
  end
endmodule

// File: rtl/selbit_mem.sv
module selbit_mem
  import selbit_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addrBits,
  input  logic          chipSel,
  input  logic          rdWr,
  inout  tri            dataLine,
  output logic          driveEn
);
  selStrobes_t strobes;
  logic        rdBit;

  selbit_ctrl #(.AW(AW)) ctrl_i (
    .clk      (clk),
    .addrBits (addrBits),
    .chipSel  (chipSel),
    .rdWr     (rdWr),
    .strobes  (strobes)
  );

  selbit_datapath #(.AW(AW)) dp_i (
    .clk      (clk),
    .addrBits (addrBits),
    .strobes  (strobes),
    .busIn    (dataLine),
    .rdBit    (rdBit)
  );

  assign driveEn  = strobes.busDrive;
  assign dataLine = driveEn ? rdBit : 1'bz;

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R9: dropping the select after a read releases the line
  a_r9_release: assert property (@(posedge clk) disable iff (!pastValid)
    !chipSel |-> !driveEn);
endmodule

// File: tb/selbit_mem_tb_top.sv
`timescale 1ns/100ps
module selbit_mem_tb_top;
  logic       clk = 1'b0;
  logic [1:0] addrBits = '0;
  logic       chipSel = 1'b0;
  logic       rdWr = 1'b1;
  logic       tbDrive = 1'b0;
  logic       tbVal = 1'b0;
  logic       driveEn;
  tri         dataLine;
  logic [3:0] model;
  int         nChk = 0;
  int         nBad = 0;

  assign dataLine = tbDrive ? tbVal : 1'bz;

  always #2 clk = ~clk;

  selbit_mem dut_i (
    .clk(clk), .addrBits(addrBits), .chipSel(chipSel), .rdWr(rdWr),
    .dataLine(dataLine), .driveEn(driveEn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // combinational read (R4, R1), then deselect and check release (R9)
  task automatic readAt(input logic [1:0] a, input string req);
    @(posedge clk); #0.5;
    tbDrive = 1'b0; chipSel = 1'b1; rdWr = 1'b1; addrBits = a;
    #0.5;
    check({req, " R4 driveEn"}, driveEn, 1'b1);
    check({req, " R1 data"}, dataLine, model[{a[1], a[0]}]);
    chipSel = 1'b0;
    #0.5;
    check("R9 release", driveEn, 1'b0);
  endtask

  task automatic writeAt(input logic [1:0] a, input logic v);
    @(posedge clk); #0.5;
    chipSel = 1'b1; rdWr = 1'b0; addrBits = a; tbDrive = 1'b1; tbVal = v;
    #0.5;
    check("R8 no drive in write", driveEn, 1'b0);
    @(negedge clk); #0.5;
    model[a] = v;
    chipSel = 1'b0; tbDrive = 1'b0;
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 4; a++) readAt(2'(a), req);
  endtask

  task automatic runTests;
    // reset-free start: nothing selected, line released
    #1;
    check("R3 initial driveEn", driveEn, 1'b0);
    model = 4'b0000;
    for (int a = 0; a < 4; a++) writeAt(2'(a), 1'b0);
    readAll("R5 init");
    // sweep every content pattern, checking neighbours after each write
    for (int p = 0; p < 16; p++) begin
      for (int a = 0; a < 4; a++) begin
        writeAt(2'(a), p[a]);
        readAll("R7 sweep");
      end
    end
    // R1 ordering: distinct pattern 0010 -> only index 1 set
    writeAt(2'd0, 1'b0); writeAt(2'd1, 1'b1); writeAt(2'd2, 1'b0); writeAt(2'd3, 1'b0);
    readAt(2'b01, "R1 low bit");
    readAt(2'b10, "R1 high bit");
    // R3: deselected with conflicting line, both directions
    for (int d = 0; d < 2; d++) begin
      @(posedge clk); #0.5;
      chipSel = 1'b0; rdWr = d[0]; addrBits = 2'd1; tbDrive = 1'b1; tbVal = ~model[1];
      #0.5;
      check("R3 deselected driveEn", driveEn, 1'b0);
      @(negedge clk); #0.5;
      tbDrive = 1'b0;
      readAll("R3 no change");
    end
    // R6: write inputs over a rising edge, turned to read before the falling edge
    @(negedge clk); #0.5;
    chipSel = 1'b1; rdWr = 1'b0; addrBits = 2'd2; tbDrive = 1'b1; tbVal = ~model[2];
    @(posedge clk); #0.5;
    tbDrive = 1'b0; rdWr = 1'b1;
    #0.5;
    check("R6 rising edge ignored", dataLine, model[2]);
    check("R2 read selects drive", driveEn, 1'b1);
    chipSel = 1'b0;
    readAll("R6 after");
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule